// File: doc/BRIEF.md
# Interleaved-Sequence Counter

This block is a small synchronous counter with a 5-bit result. It visits sixteen values in a fixed order and then starts over. The order alternates between an even value below sixteen and an odd value at sixteen or above: 0, 17, 2, 19, 4, 21, 6, 23, 8, 25, 10, 27, 12, 29, 14, 31, and then 0 again.

Internally the lower four bits form an ordinary binary counter that wraps from 15 to 0. The most significant output bit is a copy of the least significant one. This is the whole rule that turns a plain count into the interleaved order.

The block has only a clock, a synchronous active-high reset and the count output. It has no enable, no load and no direction control. Every rising clock edge either resets the count or advances it by one step.

Top module: `interleave_counter`

## Requirements
- R1: On a rising clock edge where `rst` is 1, `count_o` becomes 0, whatever its prior value.
- R2: On a rising clock edge where `rst` is 0, `count_o` moves exactly one step along the order 0, 17, 2, 19, 4, 21, 6, 23, 8, 25, 10, 27, 12, 29, 14, 31.
- R3: When `count_o` is 31 and `rst` is 0 at the next rising edge, the following value is 0.
- R4: Bit 4 of `count_o` always equals bit 0 of `count_o` once reset has been applied.
- R5: Bits 3 down to 0 of `count_o` increase by one, modulo 16, on every rising edge where `rst` is 0.
- R6: A reset in the middle of the order restarts it, so the value after the reset edge is 0 and the next non-reset edge gives 17.
- R7: While `rst` stays 1 for several edges, `count_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| count_o | output | 5 | Current value in the interleaved order |

## Verification
Every result of this block is due one rising edge after the stimulus that causes it. A reset sampled high at an edge shows 0 right after that edge, and each non-reset edge shows the next value in the order right after that edge. The bench keeps a behavioural reference that updates on the same edge. It changes `rst` and compares `count_o` with the reference on the falling edge, half a period after the register has settled. For each comparison it names the rule that applies: reset, the wrap from 31, or an ordinary step.

// File: rtl/interleave_counter_pkg.sv
// Package: shared sizing for the interleaved-sequence counter.
// Assumes the output is one bit wider than the binary core count.
package interleave_counter_pkg;
    localparam int unsigned CORE_W  = 4;
    localparam int unsigned COUNT_W = CORE_W + 1;
    typedef logic [CORE_W-1:0]  core_t;
    typedef logic [COUNT_W-1:0] count_t;
endpackage

// File: rtl/ic_core_counter.sv
// Module: ic_core_counter
// Binary up-counter of WIDTH bits that wraps at its top value and is
// cleared by a synchronous active-high reset.
// Assumes one advance per clock edge; no enable.
module ic_core_counter #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] value_o
);
    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    // Purpose: clear on reset, otherwise add one with natural wrap.
    always_ff @(posedge clk) begin
        if (rst) value_o <= '0;
        else     value_o <= value_o + STEP;
    end

    // R1: a reset edge clears the core count.
    assert_core_clear_R1: assert property (@(posedge clk) rst |=> (value_o == '0));

    // R5: a non-reset edge adds exactly one, modulo 2**WIDTH.
    assert_core_step_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (value_o == $past(value_o) + STEP));
endmodule

// File: rtl/ic_fold_map.sv
// Module: ic_fold_map
// Widens a WIDTH-bit core count by one bit, copying its least
// significant bit into the new top bit. Purely combinational.
// Assumes WIDTH >= 1.
module ic_fold_map #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] core_i,
    output logic [WIDTH:0]   count_o
);
    genvar gi;
    // Purpose: pass the lower bits through unchanged.
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_pass
            assign count_o[gi] = core_i[gi];
        end
    endgenerate

    // Purpose: the top bit mirrors the lowest core bit.
    assign count_o[WIDTH] = core_i[0];
endmodule

// File: rtl/interleave_counter.sv
// Module: interleave_counter (top)
// Produces the 16-step interleaved order 0,17,2,19,...,14,31 and repeats.
// Built from a binary core counter plus a fold that mirrors bit 0
// into the top bit. Assumes synchronous active-high reset.
module interleave_counter
    import interleave_counter_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    output logic [4:0]   count_o
);
    core_t  core_q;
    count_t folded;

    // Purpose: binary stepping of the low bits.
    ic_core_counter #(.WIDTH(CORE_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .value_o (core_q)
    );

    // Purpose: form the interleaved value from the core count.
    ic_fold_map #(.WIDTH(CORE_W)) u_fold (
        .core_i  (core_q),
        .count_o (folded)
    );

    assign count_o = folded;

    // R4: top bit and bottom bit of the output always agree.
    assert_top_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        count_o[COUNT_W-1] == count_o[0]);

    // R3: the highest value is followed by zero.
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (count_o == {COUNT_W{1'b1}}) |=> (count_o == '0));

    // R6: the first non-reset edge after a reset gives 17.
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> (count_o == 5'd17));
endmodule

// File: tb/interleave_counter_tb.sv
module interleave_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] count_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int ref_low = 0;
    int last_exp = -1;
    bit was_rst = 1'b0;

    always #2 clk = ~clk;

    interleave_counter u_dut (.clk(clk), .rst(rst), .count_o(count_o));

    // Reference: reset clears, otherwise the low nibble advances modulo 16.
    always @(posedge clk) begin
        was_rst <= rst;
        if (rst) ref_low <= 0;
        else     ref_low <= (ref_low + 1) % 16;
        cyc <= cyc + 1;
    end

    function automatic int expect_val(int low);
        return low + 16 * (low % 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: count_o=%0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare on every falling edge; the tag follows the rule in force.
    always @(negedge clk) begin
        if (cyc > 0) begin
            int e;
            e = expect_val(ref_low);
            if (was_rst)                        check("R1/R7", int'(count_o), e);
            else if (last_exp == 31)            check("R3", int'(count_o), e);
            else if (last_exp == 0 && e == 17)  check("R6", int'(count_o), e);
            else                                check("R2/R5", int'(count_o), e);
            check("R4", int'(count_o[4]), int'(count_o[0]));
            last_exp = e;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Stimulus: long run, mid-order reset, held reset, second long run.
    initial begin
        run(3);
        rst = 1'b0;
        run(40);
        rst = 1'b1;
        run(1);
        rst = 1'b0;
        run(7);
        rst = 1'b1;
        run(5);
        rst = 1'b0;
        run(35);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: run did not end, cycle %0d expected under 5000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule